// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the pixel and line counters of a raster display together with blanking, a display-enable strobe and two sets of sync pulses: one pair for a CRT and one pair for a flat panel. It runs entirely in the pixel clock domain. Software sets all timing through a write-only 32-bit register port that is synchronous to that clock. Out of reset it produces a 640x480 raster.

Every timing point is held as a pair of 11-bit values, each stored as a count minus one. Blanking is set separately from the active region and the total. The flat-panel syncs have their own positions. A key-based lock guards the timing, control and polarity registers. A write lands first in a shadow bank. The raster uses it only from the first cycle of the next frame, so a running frame is never torn.

Top module: `raster_tgen`

## Requirements
- R1: Register word addresses are 0 lock, 1 horizontal active/total, 2 horizontal blank start/end, 3 CRT horizontal sync start/end, 4 flat-panel horizontal sync start/end, 5 vertical active/total, 6 vertical blank start/end, 7 CRT vertical sync start/end, 8 flat-panel vertical sync start/end, 9 control (bit 0 = timing enable), 10 polarity. Each pair register holds its first point minus one in bits 10:0 and its second point minus one in bits 26:16. Other addresses are ignored.
- R2: While enabled, the horizontal counter runs from 0 to total-1 and then wraps to 0. The vertical counter advances only on a horizontal wrap, and it wraps to 0 after line total-1.
- R3: `de` is high only when enabled, and only when both counters are below their active value and below their blank start.
- R4: `hblank` is high for pixel counts from blank start up to but not including blank end. `vblank` is high for line counts in the same range taken from the vertical pair. Both are high while timing is disabled.
- R5: `hsync` is asserted for pixel counts from sync start up to but not including sync end. `vsync` does the same over line counts.
- R6: `fp_hsync` and `fp_vsync` follow the same rule as R5, using the flat-panel pairs (addresses 4 and 8), independently of the CRT pairs.
- R7: Polarity bit 0 governs both horizontal syncs and bit 1 governs both vertical syncs. A 1 makes the pulse active low and a 0 makes it active high. A new polarity value applies from the cycle after the write.
- R8: Writing the 32-bit key parameter to address 0 opens the lock. Writing any other value to address 0 closes it.
- R9: While the lock is closed, writes to addresses 1 to 10 change nothing that can be observed.
- R10: New pair values are used only from the first cycle of the next frame, i.e. from the cycle in which both counters return to 0. Until then the running frame keeps the old values.
- R11: When the enable bit is clear, both counters are held at 0 from the next cycle on and every sync sits at its inactive level. Values written while disabled are in force from the first counted cycle after enable is set.
- R12: After reset the lock is closed, timing is disabled and both polarity bits are 1. The pairs hold the 640x480 mode: active 640/480, sync 664-704 and 489-491, totals 832/520, blank equal to active/total, flat-panel horizontal sync equal to the CRT one, and flat-panel vertical sync one line earlier (488-490).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | DATA_W | Register write data |
| h_count | output | 11 | Pixel position in the line |
| v_count | output | 11 | Line position in the frame |
| de | output | 1 | Display enable |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| hsync | output | 1 | CRT horizontal sync |
| vsync | output | 1 | CRT vertical sync |
| fp_hsync | output | 1 | Flat-panel horizontal sync |
| fp_vsync | output | 1 | Flat-panel vertical sync |

## Verification
The hardest situation to reach is a change of timing that lands partway through a frame. A full frame of the reference modes lasts hundreds of thousands of cycles. To get around this, the stimulus writes new pairs while counting and confirms that the old line total is still in force. It then restarts the raster through the enable bit, which reloads the live bank at once. Very small programmed modes, about a hundred cycles per frame, carry the raster across several frame boundaries while writes are pending. A key mismatch then shows that locked writes change neither the totals nor the enable.

// File: rtl/raster_tgen_pkg.sv
package raster_tgen_pkg;

    localparam int FIELD_W    = 11;
    localparam int SECOND_LSB = 16;
    localparam int NUM_PAIRS  = 8;
    localparam int NUM_SYNCS  = 4;

    localparam int IX_H_MAIN  = 0;
    localparam int IX_H_BLANK = 1;
    localparam int IX_H_SYNC  = 2;
    localparam int IX_H_FP    = 3;
    localparam int IX_V_MAIN  = 4;
    localparam int IX_V_BLANK = 5;
    localparam int IX_V_SYNC  = 6;
    localparam int IX_V_FP    = 7;

    localparam int ADDR_LOCK      = 0;
    localparam int ADDR_PAIR_BASE = 1;
    localparam int ADDR_CTRL      = ADDR_PAIR_BASE + NUM_PAIRS;
    localparam int ADDR_POL       = ADDR_CTRL + 1;

    typedef logic [FIELD_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t second;
        cnt_t first;
    } pair_t;

    typedef pair_t [NUM_PAIRS-1:0] pair_bank_t;
    typedef pair_t [NUM_SYNCS-1:0] sync_bank_t;

    typedef struct packed {
        logic       enable;
        logic [1:0] pol;
    } ctrl_t;

    typedef struct packed {
        logic de;
        logic hblank;
        logic vblank;
        logic hsync;
        logic vsync;
        logic fp_hsync;
        logic fp_vsync;
    } raster_out_t;

    function automatic pair_t pair_of(int a, int b);
        pair_t p;
        p.first  = cnt_t'(a - 1);
        p.second = cnt_t'(b - 1);
        return p;
    endfunction

    function automatic pair_bank_t build_bank(int ha, int hss, int hse, int ht,
                                              int va, int vss, int vse, int vt);
        pair_bank_t b;
        b[IX_H_MAIN]  = pair_of(ha, ht);
        b[IX_H_BLANK] = pair_of(ha, ht);
        b[IX_H_SYNC]  = pair_of(hss, hse);
        b[IX_H_FP]    = pair_of(hss, hse);
        b[IX_V_MAIN]  = pair_of(va, vt);
        b[IX_V_BLANK] = pair_of(va, vt);
        b[IX_V_SYNC]  = pair_of(vss, vse);
        b[IX_V_FP]    = pair_of(vss - 1, vse - 1);
        return b;
    endfunction

    // Count lies strictly above first-1 and at or below second-1.
    function automatic logic in_window(cnt_t c, pair_t p);
        return (c > p.first) && (c <= p.second);
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import raster_tgen_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 'hA55A0F1E,
    parameter pair_bank_t        RESET_BANK = '0,
    parameter logic [1:0]        RESET_POL  = 2'b11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output pair_bank_t        shadow,
    output ctrl_t             ctrl,
    output logic              unlocked
);

    logic  wr_open;
    logic  hit_lock;
    pair_t wr_pair;

    assign hit_lock = wr_en && (wr_addr == ADDR_W'(ADDR_LOCK));
    assign wr_open  = wr_en && unlocked;
    assign wr_pair  = '{second: wr_data[SECOND_LSB +: FIELD_W],
                        first:  wr_data[FIELD_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (hit_lock) begin
            unlocked <= (wr_data == UNLOCK_KEY);
        end
    end

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        pair_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RESET_BANK[g];
            end else if (wr_open && (wr_addr == ADDR_W'(ADDR_PAIR_BASE + g))) begin
                q <= wr_pair;
            end
        end
        assign shadow[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.enable <= 1'b0;
            ctrl.pol    <= RESET_POL;
        end else if (wr_open) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
                ctrl.enable <= wr_data[0];
            end
            if (wr_addr == ADDR_W'(ADDR_POL)) begin
                ctrl.pol <= wr_data[1:0];
            end
        end
    end

endmodule

// File: rtl/rtg_frame_latch.sv
module rtg_frame_latch
    import raster_tgen_pkg::*;
#(
    parameter pair_bank_t RESET_BANK = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  pair_bank_t shadow,
    output pair_bank_t active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= RESET_BANK;
        end else if (load) begin
            active <= shadow;
        end
    end

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter
    import raster_tgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  cnt_t h_last,
    input  cnt_t v_last,
    output cnt_t h_cnt,
    output cnt_t v_cnt,
    output logic frame_load
);

    logic h_wrap;
    logic v_wrap;

    assign h_wrap     = (h_cnt == h_last);
    assign v_wrap     = (v_cnt == v_last);
    assign frame_load = !enable || (h_wrap && v_wrap);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_wrap) begin
            h_cnt <= '0;
            v_cnt <= v_wrap ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
    import raster_tgen_pkg::*;
(
    input  logic        enable,
    input  logic [1:0]  pol,
    input  cnt_t        h_cnt,
    input  cnt_t        v_cnt,
    input  cnt_t        h_act_last,
    input  cnt_t        v_act_last,
    input  pair_t       h_blank,
    input  pair_t       v_blank,
    input  sync_bank_t  sync_pairs,
    output raster_out_t outs
);

    logic [NUM_SYNCS-1:0] pin;
    logic                 in_h;
    logic                 in_v;

    assign in_h = (h_cnt <= h_act_last) && (h_cnt <= h_blank.first);
    assign in_v = (v_cnt <= v_act_last) && (v_cnt <= v_blank.first);

    // Entries 0,1 are horizontal (CRT, panel); 2,3 vertical (CRT, panel).
    for (genvar g = 0; g < NUM_SYNCS; g++) begin : g_sync
        localparam int AX = g / 2;
        cnt_t pos;
        assign pos    = (AX == 1) ? v_cnt : h_cnt;
        assign pin[g] = (enable && in_window(pos, sync_pairs[g])) ^ pol[AX];
    end

    always_comb begin
        outs.de       = enable && in_h && in_v;
        outs.hblank   = !enable || in_window(h_cnt, h_blank);
        outs.vblank   = !enable || in_window(v_cnt, v_blank);
        outs.hsync    = pin[0];
        outs.fp_hsync = pin[1];
        outs.vsync    = pin[2];
        outs.fp_vsync = pin[3];
    end

endmodule

// File: rtl/raster_tgen.sv
module raster_tgen
    import raster_tgen_pkg::*;
#(
    parameter int                ADDR_W       = 4,
    parameter int                DATA_W       = 32,
    parameter logic [DATA_W-1:0] UNLOCK_KEY   = 'hA55A0F1E,
    parameter int                H_ACTIVE     = 640,
    parameter int                H_SYNC_START = 664,
    parameter int                H_SYNC_END   = 704,
    parameter int                H_TOTAL      = 832,
    parameter int                V_ACTIVE     = 480,
    parameter int                V_SYNC_START = 489,
    parameter int                V_SYNC_END   = 491,
    parameter int                V_TOTAL      = 520,
    parameter logic [1:0]        RESET_POL    = 2'b11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [FIELD_W-1:0] h_count,
    output logic [FIELD_W-1:0] v_count,
    output logic               de,
    output logic               hblank,
    output logic               vblank,
    output logic               hsync,
    output logic               vsync,
    output logic               fp_hsync,
    output logic               fp_vsync
);

    localparam pair_bank_t RESET_BANK = build_bank(H_ACTIVE, H_SYNC_START, H_SYNC_END, H_TOTAL,
                                                   V_ACTIVE, V_SYNC_START, V_SYNC_END, V_TOTAL);

    pair_bank_t  shadow;
    pair_bank_t  active;
    ctrl_t       ctrl;
    logic        unlocked;
    logic        frame_load;
    cnt_t        h_cnt;
    cnt_t        v_cnt;
    sync_bank_t  sync_pairs;
    raster_out_t outs;

    rtg_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .UNLOCK_KEY (UNLOCK_KEY),
        .RESET_BANK (RESET_BANK),
        .RESET_POL  (RESET_POL)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .shadow   (shadow),
        .ctrl     (ctrl),
        .unlocked (unlocked)
    );

    rtg_frame_latch #(
        .RESET_BANK (RESET_BANK)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_load),
        .shadow (shadow),
        .active (active)
    );

    rtg_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .enable     (ctrl.enable),
        .h_last     (active[IX_H_MAIN].second),
        .v_last     (active[IX_V_MAIN].second),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .frame_load (frame_load)
    );

    assign sync_pairs = {active[IX_V_FP], active[IX_V_SYNC], active[IX_H_FP], active[IX_H_SYNC]};

    rtg_decode u_dec (
        .enable     (ctrl.enable),
        .pol        (ctrl.pol),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .h_act_last (active[IX_H_MAIN].first),
        .v_act_last (active[IX_V_MAIN].first),
        .h_blank    (active[IX_H_BLANK]),
        .v_blank    (active[IX_V_BLANK]),
        .sync_pairs (sync_pairs),
        .outs       (outs)
    );

    assign h_count  = h_cnt;
    assign v_count  = v_cnt;
    assign de       = outs.de;
    assign hblank   = outs.hblank;
    assign vblank   = outs.vblank;
    assign hsync    = outs.hsync;
    assign vsync    = outs.vsync;
    assign fp_hsync = outs.fp_hsync;
    assign fp_vsync = outs.fp_vsync;

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import raster_tgen_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              unlocked,
    input ctrl_t             ctrl,
    input pair_bank_t        shadow,
    input pair_bank_t        active,
    input cnt_t              h_count,
    input cnt_t              v_count,
    input logic              de,
    input logic              hsync,
    input logic              vsync,
    input logic              fp_hsync,
    input logic              fp_vsync
);

    assert_hold_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> (h_count == '0 && v_count == '0));

    assert_sync_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |-> (hsync == ctrl.pol[0] && fp_hsync == ctrl.pol[0] &&
                          vsync == ctrl.pol[1] && fp_vsync == ctrl.pol[1]));

    assert_h_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (h_count == active[IX_H_MAIN].second) |=> (h_count == '0));

    assert_h_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && h_count != active[IX_H_MAIN].second)
            |=> (h_count == cnt_t'($past(h_count) + 1'b1)));

    assert_v_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && h_count != active[IX_H_MAIN].second) |=> $stable(v_count));

    assert_frame_swap_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> (h_count == '0 && v_count == '0));

    assert_locked_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !unlocked && wr_addr != ADDR_W'(ADDR_LOCK))
            |=> ($stable(shadow) && $stable(ctrl)));

    assert_de_inside_R3: assert property (@(posedge clk) disable iff (rst)
        de |-> (ctrl.enable && h_count <= active[IX_H_BLANK].first &&
                v_count <= active[IX_V_BLANK].first));

endmodule

bind raster_tgen rtg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .unlocked (unlocked),
    .ctrl     (ctrl),
    .shadow   (shadow),
    .active   (active),
    .h_count  (h_count),
    .v_count  (v_count),
    .de       (de),
    .hsync    (hsync),
    .vsync    (vsync),
    .fp_hsync (fp_hsync),
    .fp_vsync (fp_vsync)
);

// File: tb/raster_tgen_test.sv
`timescale 1ns/100ps
module raster_tgen_test;

    localparam logic [31:0] KEY = 32'hA55A0F1E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [10:0] h_count, v_count;
    logic        de, hblank, vblank, hsync, vsync, fp_hsync, fp_vsync;

    raster_tgen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .h_count(h_count), .v_count(v_count), .de(de), .hblank(hblank), .vblank(vblank),
        .hsync(hsync), .vsync(vsync), .fp_hsync(fp_hsync), .fp_vsync(fp_vsync)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Behavioural reference: shadow and live values per pair (minus-one form).
    int sh_f[8], sh_s[8], ac_f[8], ac_s[8];
    int m_h, m_v;
    bit m_unl, m_en, m_load, m_valid = 0;
    bit [1:0] m_pol;

    function automatic logic [31:0] pw(int a, int b);
        return (32'(b - 1) << 16) | 32'(a - 1);
    endfunction

    task automatic set_sh(int i, int a, int b);
        sh_f[i] = a - 1;
        sh_s[i] = b - 1;
    endtask

    task automatic model_reset();
        set_sh(0, 640, 832); set_sh(1, 640, 832); set_sh(2, 664, 704); set_sh(3, 664, 704);
        set_sh(4, 480, 520); set_sh(5, 480, 520); set_sh(6, 489, 491); set_sh(7, 488, 490);
        ac_f = sh_f; ac_s = sh_s;
        m_h = 0; m_v = 0; m_unl = 0; m_en = 0; m_pol = 2'b11; m_valid = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else if (m_valid) begin
            m_load = !m_en || (m_h == ac_s[0] && m_v == ac_s[4]);
            if (!m_en) begin
                m_h = 0; m_v = 0;
            end else if (m_h == ac_s[0]) begin
                m_h = 0;
                m_v = (m_v == ac_s[4]) ? 0 : m_v + 1;
            end else begin
                m_h = m_h + 1;
            end
            if (m_load) begin
                ac_f = sh_f; ac_s = sh_s;
            end
            if (wr_en) begin
                if (wr_addr == 0) m_unl = (wr_data == KEY);
                else if (m_unl) begin
                    if (wr_addr >= 1 && wr_addr <= 8) begin
                        sh_f[int'(wr_addr) - 1] = int'(wr_data[10:0]);
                        sh_s[int'(wr_addr) - 1] = int'(wr_data[26:16]);
                    end else if (wr_addr == 9) m_en = wr_data[0];
                    else if (wr_addr == 10) m_pol = wr_data[1:0];
                end
            end
        end
    end

    function automatic bit win(int c, int i);
        return (c > ac_f[i]) && (c <= ac_s[i]);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (model h=%0d v=%0d) at %0t",
                     tag, what, act, exp, m_h, m_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            check("R2", "h_count", int'(h_count), m_h);
            check("R2", "v_count", int'(v_count), m_v);
            check("R3", "de", int'(de),
                  int'(m_en && m_h <= ac_f[0] && m_h <= ac_f[1] && m_v <= ac_f[4] && m_v <= ac_f[5]));
            check("R4", "hblank", int'(hblank), int'(!m_en || win(m_h, 1)));
            check("R4", "vblank", int'(vblank), int'(!m_en || win(m_v, 5)));
            check("R5", "hsync", int'(hsync), int'((m_en && win(m_h, 2)) ^ m_pol[0]));
            check("R5", "vsync", int'(vsync), int'((m_en && win(m_v, 6)) ^ m_pol[1]));
            check("R6", "fp_hsync", int'(fp_hsync), int'((m_en && win(m_h, 3)) ^ m_pol[0]));
            check("R6", "fp_vsync", int'(fp_vsync), int'((m_en && win(m_v, 7)) ^ m_pol[1]));
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_h(string tag, int target);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (int'(h_count) == target) return;
        end
        check(tag, "h_count never reached", int'(h_count), target);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual running expected done");
        finish_run();
    end

    initial begin
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", "reset hsync idle high", int'(hsync), 1);
        check("R12", "reset vsync idle high", int'(vsync), 1);
        check("R12", "reset de", int'(de), 0);
        check("R12", "reset hblank", int'(hblank), 1);
        @(posedge clk); #1 rst = 1'b0;

        // R9: locked control write is dropped
        wr(9, 32'h1);
        repeat (10) @(negedge clk);
        check("R9", "counter held while locked", int'(h_count), 0);

        // R8: unlock then enable default mode
        wr(0, KEY);
        wr(9, 32'h1);
        repeat (5) @(negedge clk);
        check("R8", "counting after unlock", int'(h_count != 0), 1);

        // R7/R5: default mode, active-low horizontal sync 664..703
        wait_h("R7", 663);
        check("R7", "hsync idle before start", int'(hsync), 1);
        @(negedge clk);
        check("R7", "hsync low at 664", int'(hsync), 0);
        wait_h("R5", 704);
        check("R5", "hsync released at 704", int'(hsync), 1);

        // R10: reprogram second mode mid-frame; old total stays
        wr(1, pw(1280, 1688)); wr(2, pw(1280, 1688)); wr(3, pw(1328, 1440));
        wr(4, pw(1328, 1440)); wr(5, pw(1024, 1066)); wr(6, pw(1024, 1066));
        wr(7, pw(1025, 1028)); wr(8, pw(1024, 1027)); wr(10, 32'h0);
        wait_h("R10", 831);
        @(negedge clk);
        check("R10", "old total kept mid-frame", int'(h_count), 0);

        // R11: restart through enable loads new bank
        wr(9, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R11", "counter zero when disabled", int'(h_count), 0);
        wr(9, 32'h1);
        wait_h("R7", 1328);
        check("R7", "active-high hsync at 1328", int'(hsync), 1);
        wait_h("R5", 1440);
        check("R5", "hsync ends at 1440", int'(hsync), 0);
        wait_h("R1", 1687);
        @(negedge clk);
        check("R1", "total field wraps at 1688", int'(h_count), 0);

        // Small mode A: blank decoupled from active, panel sync apart
        wr(9, 32'h0);
        wr(1, pw(8, 14)); wr(2, pw(10, 14)); wr(3, pw(11, 13)); wr(4, pw(3, 5));
        wr(5, pw(4, 7));  wr(6, pw(4, 7));   wr(7, pw(5, 6));   wr(8, pw(4, 5));
        wr(10, 32'h1);
        wr(9, 32'h1);
        wait_h("R3", 8);
        check("R3", "de low past active", int'(de), 0);
        check("R4", "hblank low before blank start", int'(hblank), 0);
        wait_h("R4", 10);
        check("R4", "hblank high at blank start", int'(hblank), 1);
        wait_h("R6", 3);
        check("R6", "fp_hsync low at 3", int'(fp_hsync), 0);
        check("R6", "crt hsync idle at 3", int'(hsync), 1);
        repeat (300) @(negedge clk);

        // Small mode B written while running: swaps at a frame boundary
        wr(1, pw(6, 9)); wr(2, pw(6, 9)); wr(3, pw(7, 8)); wr(4, pw(1, 2));
        wr(5, pw(3, 5)); wr(6, pw(3, 5)); wr(7, pw(3, 4)); wr(8, pw(2, 3));
        wr(10, 32'h2);
        repeat (300) @(negedge clk);

        // R8/R9: wrong key locks; later writes change nothing
        wr(0, KEY ^ 32'h1);
        wr(9, 32'h0);
        wr(1, pw(4, 20));
        wait_h("R9", 8);
        @(negedge clk);
        check("R9", "total unchanged after locked write", int'(h_count), 0);
        repeat (100) @(negedge clk);
        check("R9", "still enabled after locked write", int'(vblank == 1 && hblank == 1 && h_count == 0 && v_count == 0 ? 0 : 1), 1);

        // R11: disable holds counters, syncs inactive (pol = 2'b10)
        wr(0, KEY);
        wr(9, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R11", "h held at zero", int'(h_count), 0);
        check("R11", "hsync inactive high-active", int'(hsync), 0);
        check("R11", "vsync inactive low-active", int'(vsync), 1);
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule